// File: doc/BRIEF.md
# Flagged Character Port with Interrupt Gating

This block gives a small processor one character input channel and one character output channel, both reached through a four-register window. An external device hands in characters with a one-cycle strobe. Each accepted character sets a "character waiting" flag. The CPU takes the character by reading the input data register, and that read clears the flag. While a character is waiting, any further strobe is turned away and the waiting character stays intact. A sticky "lost character" bit records each refused strobe until software reads the status register.

On the output side, a "ready for output" flag is high while the output register is empty. A CPU write loads the register and drops the flag. The device sends an acknowledge once it has taken the character, and that raises the flag again. Both flags can raise an interrupt. The request is gated by an enable bit that software turns on and off through a control register. Polling software can read every flag from the status register and nothing changes as a result, except that the lost-character bit is cleared.

Top module: `flag_io_port`

## Requirements
- R1: After reset, both data registers are 0, the waiting flag is 0, the ready-for-output flag is 1, the enable is 0, the lost-character bit is 0, and irq and cpu_rdata are 0.
- R2: A strobe that arrives while the waiting flag is 0 loads dev_in_data into the input register and sets the waiting flag at that clock edge.
- R3: A strobe that arrives while the waiting flag is 1 is refused. The held character is unchanged, the flag stays 1 and the lost-character bit is set. This also applies in the same cycle as a consuming read.
- R4: A CPU read of address 0 returns the input register on cpu_rdata one clock later and clears the waiting flag.
- R5: A read of address 2 returns status with the waiting flag in bit 0, the ready flag in bit 1, the lost-character bit in bit 2 and the enable in bit 7. Every other bit is 0. The read leaves the flags unchanged and clears the lost-character bit, but a refused strobe in the same cycle keeps that bit set.
- R6: A CPU write to address 1 loads the output register, which is visible on dev_out_data, and clears the ready flag. This holds even when dev_out_ack arrives in the same cycle. A read of address 1 returns the register and changes nothing.
- R7: dev_out_ack with no write to address 1 in the same cycle sets the ready flag.
- R8: A write to address 3 sets the enable if wdata bit 0 is 1 and clears it if wdata bit 1 is 1. Clearing wins when both bits are 1, and the enable is unchanged when neither is 1.
- R9: irq equals enable AND (waiting flag OR ready flag), sampled one clock edge after those state bits change.
- R10: CPU writes to addresses 0 and 2 have no effect on any register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU access this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Register address: 0 input, 1 output, 2 status, 3 control |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Registered read data, holds the last read value |
| dev_in_stb | input | 1 | Device delivers a character |
| dev_in_data | input | DATA_W | Character from the device |
| dev_in_full | output | 1 | Waiting flag |
| dev_out_ack | input | 1 | Device has taken the output character |
| dev_out_data | output | DATA_W | Output register |
| dev_out_empty | output | 1 | Ready-for-output flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The flags, the enable, the lost-character bit and the output register all change at the clock edge that samples the request. Read data appears on cpu_rdata at that same edge. The interrupt request follows one edge later. The bench drives every request on a falling edge and checks flags and read data at the next falling edge. Before it checks irq, it waits one more full cycle. Sweeps cover every character value in both directions and all eight enable and flag combinations for the request.

// File: rtl/flag_io_pkg.sv
package flag_io_pkg;
  localparam int unsigned REG_IN   = 0;
  localparam int unsigned REG_OUT  = 1;
  localparam int unsigned REG_STAT = 2;
  localparam int unsigned REG_CTRL = 3;

  localparam int unsigned ST_WAIT  = 0;
  localparam int unsigned ST_READY = 1;
  localparam int unsigned ST_LOST  = 2;
  localparam int unsigned ST_EN    = 7;

  localparam int unsigned CTRL_ON  = 0;
  localparam int unsigned CTRL_OFF = 1;
endpackage

// File: rtl/fio_in_chan.sv
module fio_in_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [DATA_W-1:0] sdata,
  input  logic              consume,
  input  logic              clr_lost,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              lost_q
);
  logic accept;
  logic refuse;

  assign accept = stb && !full_q;
  assign refuse = stb && full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      data_q <= sdata;
      full_q <= 1'b1;
    end else if (consume) begin
      full_q <= 1'b0;
    end
  end

  // a fresh refusal outranks the clear from a status read
  always_ff @(posedge clk) begin
    if (rst)           lost_q <= 1'b0;
    else if (refuse)   lost_q <= 1'b1;
    else if (clr_lost) lost_q <= 1'b0;
  end
endmodule

// File: rtl/fio_out_chan.sv
module fio_out_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (load) begin
      data_q  <= wdata;
      empty_q <= 1'b0;
    end else if (ack) begin
      empty_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fio_irq_ctl.sv
module fio_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic en_on,
  input  logic en_off,
  input  logic src_wait,
  input  logic src_ready,
  output logic ien_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
    end else if (ctrl_wr) begin
      if (en_off)     ien_q <= 1'b0;
      else if (en_on) ien_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ien_q && (src_wait || src_ready);
  end
endmodule

// File: rtl/flag_io_port.sv
module flag_io_port
  import flag_io_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              dev_in_stb,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_full,
  input  logic              dev_out_ack,
  output logic [DATA_W-1:0] dev_out_data,
  output logic              dev_out_empty,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(REG_IN);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(REG_OUT);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);

  logic              rd_en, wr_en;
  logic              rd_in, rd_stat, wr_out, wr_ctrl;
  logic [DATA_W-1:0] in_data_q, out_data_q, status_w;
  logic              fgi_q, fgo_q, lost_q, ien_q, irq_q;

  assign rd_en   = cpu_sel && !cpu_wr;
  assign wr_en   = cpu_sel && cpu_wr;
  assign rd_in   = rd_en && (cpu_addr == A_IN);
  assign rd_stat = rd_en && (cpu_addr == A_STAT);
  assign wr_out  = wr_en && (cpu_addr == A_OUT);
  assign wr_ctrl = wr_en && (cpu_addr == A_CTRL);

  fio_in_chan #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .stb(dev_in_stb), .sdata(dev_in_data),
    .consume(rd_in), .clr_lost(rd_stat),
    .data_q(in_data_q), .full_q(fgi_q), .lost_q(lost_q)
  );

  fio_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .load(wr_out), .wdata(cpu_wdata),
    .ack(dev_out_ack), .data_q(out_data_q), .empty_q(fgo_q)
  );

  fio_irq_ctl u_irq (
    .clk(clk), .rst(rst), .ctrl_wr(wr_ctrl),
    .en_on(cpu_wdata[CTRL_ON]), .en_off(cpu_wdata[CTRL_OFF]),
    .src_wait(fgi_q), .src_ready(fgo_q),
    .ien_q(ien_q), .irq_q(irq_q)
  );

  always_comb begin
    status_w           = '0;
    status_w[ST_WAIT]  = fgi_q;
    status_w[ST_READY] = fgo_q;
    status_w[ST_LOST]  = lost_q;
    status_w[ST_EN]    = ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (rd_en) begin
      case (cpu_addr)
        A_IN:    cpu_rdata <= in_data_q;
        A_OUT:   cpu_rdata <= out_data_q;
        A_STAT:  cpu_rdata <= status_w;
        default: cpu_rdata <= '0;
      endcase
    end
  end

  assign dev_in_full   = fgi_q;
  assign dev_out_data  = out_data_q;
  assign dev_out_empty = fgo_q;
  assign irq           = irq_q;
endmodule

// File: rtl/flag_io_port_chk.sv
module flag_io_port_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_sel,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              dev_in_stb,
  input logic              dev_in_full,
  input logic              dev_out_ack,
  input logic              dev_out_empty,
  input logic              irq,
  input logic [DATA_W-1:0] in_data,
  input logic              lost,
  input logic              ien
);
  logic wr_out_c;
  assign wr_out_c = cpu_sel && cpu_wr && (cpu_addr == ADDR_W'(1));

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    dev_in_stb && !dev_in_full |=> dev_in_full); // R2
  AST_FULL_HOLDS_CHAR: assert property (@(posedge clk) disable iff (rst)
    dev_in_stb && dev_in_full |=> $stable(in_data)); // R3
  AST_FULL_MARKS_LOST: assert property (@(posedge clk) disable iff (rst)
    dev_in_stb && dev_in_full |=> lost); // R3
  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    wr_out_c |=> !dev_out_empty); // R6
  AST_ACK_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    dev_out_ack && !wr_out_c |=> dev_out_empty); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq); // R9
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    ien && (dev_in_full || dev_out_empty) |=> irq); // R9
endmodule

bind flag_io_port flag_io_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .dev_in_stb(dev_in_stb), .dev_in_full(dev_in_full), .dev_out_ack(dev_out_ack),
  .dev_out_empty(dev_out_empty), .irq(irq), .in_data(in_data_q),
  .lost(lost_q), .ien(ien_q)
);

// File: tb/sim_flag_io_port.sv
module sim_flag_io_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic       dev_in_stb = 1'b0;
  logic [7:0] dev_in_data = '0;
  logic       dev_in_full, dev_out_ack = 1'b0, dev_out_empty, irq;
  logic [7:0] dev_out_data;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  flag_io_port u0 (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dev_in_stb(dev_in_stb),
    .dev_in_data(dev_in_data), .dev_in_full(dev_in_full), .dev_out_ack(dev_out_ack),
    .dev_out_data(dev_out_data), .dev_out_empty(dev_out_empty), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, return at next falling edge
  task automatic op(input logic sel, input logic wr, input logic [1:0] a,
                    input logic [7:0] wd, input logic stb, input logic [7:0] sd,
                    input logic ack);
    cpu_sel = sel; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
    dev_in_stb = stb; dev_in_data = sd; dev_out_ack = ack;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0; dev_in_stb = 1'b0; dev_out_ack = 1'b0;
  endtask

  task automatic idle();   op(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(input logic [1:0] a); op(1, 0, a, 0, 0, 0, 0); endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d); op(1, 1, a, d, 0, 0, 0); endtask
  task automatic stb(input logic [7:0] d); op(0, 0, 0, 0, 1, d, 0); endtask
  task automatic ack(); op(0, 0, 0, 0, 0, 0, 1); endtask

  function automatic logic [7:0] st(input logic e, input logic l, input logic r, input logic w);
    return {e, 4'b0, l, r, w};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", cpu_rdata, 8'h00);
    chk("R1 full", {7'b0, dev_in_full}, 8'h00);
    chk("R1 empty", {7'b0, dev_out_empty}, 8'h01);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 outdata", dev_out_data, 8'h00);
    rd(2); chk("R1 status", cpu_rdata, st(0, 0, 1, 0));
    rd(0); chk("R1 indata", cpu_rdata, 8'h00);

    // R2 R3 R4 R5 sweep of every input character
    for (int c = 0; c < 256; c++) begin
      stb(8'(c));
      chk("R2 full set", {7'b0, dev_in_full}, 8'h01);
      stb(~8'(c));
      chk("R3 stays full", {7'b0, dev_in_full}, 8'h01);
      rd(2); chk("R5 status lost", cpu_rdata, st(0, 1, 1, 1));
      chk("R5 flags kept", {7'b0, dev_in_full}, 8'h01);
      rd(0); chk("R4 R3 data kept", cpu_rdata, 8'(c));
      chk("R4 full cleared", {7'b0, dev_in_full}, 8'h00);
      rd(2); chk("R5 lost cleared", cpu_rdata, st(0, 0, 1, 0));
    end

    // R3 refusal during consuming read
    stb(8'h11);
    op(1, 0, 0, 0, 1, 8'h22, 0);
    chk("R3 read with stb", cpu_rdata, 8'h11);
    chk("R3 full after", {7'b0, dev_in_full}, 8'h00);
    // R5 refused strobe beats clear in same cycle
    stb(8'h33);
    op(1, 0, 2, 0, 1, 8'h44, 0);
    chk("R5 status same cycle", cpu_rdata, st(0, 1, 1, 1));
    rd(2); chk("R5 lost kept", cpu_rdata, st(0, 1, 1, 1));
    rd(0); chk("R3 held 33", cpu_rdata, 8'h33);
    rd(2); chk("R5 clean", cpu_rdata, st(0, 0, 1, 0));

    // R6 R7 sweep of every output character
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v));
      chk("R6 outdata", dev_out_data, 8'(v));
      chk("R6 empty cleared", {7'b0, dev_out_empty}, 8'h00);
      rd(1); chk("R6 readback", cpu_rdata, 8'(v));
      chk("R6 read no effect", {7'b0, dev_out_empty}, 8'h00);
      ack(); chk("R7 ack", {7'b0, dev_out_empty}, 8'h01);
    end
    op(1, 1, 1, 8'h5A, 0, 0, 1);
    chk("R6 write beats ack", {7'b0, dev_out_empty}, 8'h00);
    chk("R6 data 5A", dev_out_data, 8'h5A);
    ack(); chk("R7 ack again", {7'b0, dev_out_empty}, 8'h01);

    // R10 writes to read-only addresses
    stb(8'h3C);
    wr(0, 8'h55);
    chk("R10 full kept", {7'b0, dev_in_full}, 8'h01);
    wr(2, 8'hFF);
    rd(2); chk("R10 status unchanged", cpu_rdata, st(0, 0, 1, 1));
    rd(0); chk("R10 indata kept", cpu_rdata, 8'h3C);

    // R8 control
    wr(3, 8'h01); rd(2); chk("R8 on", cpu_rdata, st(1, 0, 1, 0));
    wr(3, 8'h00); rd(2); chk("R8 none", cpu_rdata, st(1, 0, 1, 0));
    wr(3, 8'h02); rd(2); chk("R8 off", cpu_rdata, st(0, 0, 1, 0));
    wr(3, 8'h01); wr(3, 8'h03); rd(2); chk("R8 off wins", cpu_rdata, st(0, 0, 1, 0));

    // R9 all enable/flag combinations
    for (int k = 0; k < 8; k++) begin
      logic e, f, o;
      e = k[2]; f = k[1]; o = k[0];
      if (o) ack(); else wr(1, 8'(k));
      if (f) begin rd(0); stb(8'(k)); end else rd(0);
      wr(3, e ? 8'h01 : 8'h02);
      idle();
      chk("R9 irq combo", {7'b0, irq}, {7'b0, e & (f | o)});
    end
    // R9 one-edge lag: enable on, both flags low, then strobe
    wr(1, 8'h00); rd(0); wr(3, 8'h01); idle();
    chk("R9 low", {7'b0, irq}, 8'h00);
    stb(8'h77);
    chk("R9 not yet", {7'b0, irq}, 8'h00);
    idle();
    chk("R9 raised", {7'b0, irq}, 8'h01);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule